// File: doc/BRIEF.md
# Edge/Level Interrupt Pin Arbiter

This block sits inside an interrupt router and owns the per-pin request logic. Every cycle it samples one raw input level per pin and corrects each level for the pin's polarity. It remembers whether each pin is pending. Using the pin's routing entry, it decides when that pin must produce a delivery message. Each entry selects edge or level behaviour. In level mode, a remote-IRR interlock stops a second delivery until an end-of-interrupt (EOI) with the matching vector arrives.

The routing entries come from an external register table as flattened configuration buses. The block keeps the remote-IRR bits itself and presents them on `remote_irr`, so the table can show them to software. Software flags a rewritten entry with a one-cycle notification. An EOI arrives as a one-cycle strobe that carries a vector number.

Messages leave through a valid/ready handshake. When several pins want service at once, the lowest-numbered pin goes first, one message per transfer. A pin that changes level before clock edge k is presented on `msg_valid` after edge k+1.

Top module: `irq_pin_arbiter`

## Requirements
- R1: After reset `msg_valid` is 0 and every bit of `remote_irr` is 0.
- R2: The input level of a pin is XORed with its `cfg_pol` bit before any other use. A pin with `cfg_pol`=1 is active when its input is low.
- R3: An edge-mode pin (`cfg_trig`=0) produces exactly one message each time its effective level goes from 0 to 1. Holding the level high produces nothing more. The message's `msg_trig` is 0.
- R4: A level-mode pin (`cfg_trig`=1) produces a message whenever its effective level is 1 and its remote-IRR bit is 0. The message's `msg_trig` is 1.
- R5: Loading a level-mode pin's message sets that pin's `remote_irr` bit. While the bit is set, no further message comes from that pin.
- R6: An EOI clears `remote_irr` for every level-mode pin whose `cfg_vec` equals `eoi_vec`. If such a pin is unmasked and still pending, it is delivered again. An EOI with a non-matching vector changes nothing.
- R7: An effective level of 0 clears the pin's pending state. A level-mode pin that dropped before its EOI is not delivered again after that EOI.
- R8: A pin whose `cfg_mask` bit is 1 never produces a message. An edge that rises while the pin is masked is discarded.
- R9: A rewrite notification (`rew_valid` with `rew_pin`) clears that pin's `remote_irr`. A level-mode pin that is pending and unmasked is then serviced again.
- R10: Messages from pin 0 always carry `msg_dmode`=0 (physical) and `msg_dest`=`BOOT_DEST`, whatever the entry holds. Other pins carry their entry's destination and mode unchanged.
- R11: Every message has `msg_assert`=1 and `msg_shorthand`=0.
- R12: Pins that compete are served lowest index first, one per handshake. While `msg_valid` is 1 and `msg_ready` is 0, the message does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NPINS | Raw interrupt input levels |
| cfg_mask | input | NPINS | Per-pin mask from the routing table |
| cfg_pol | input | NPINS | Per-pin polarity inversion |
| cfg_trig | input | NPINS | Per-pin trigger kind, 1 = level, 0 = edge |
| cfg_vec | input | NPINS*VEC_W | Per-pin vector, pin i at bits [i*VEC_W +: VEC_W] |
| cfg_dest | input | NPINS*DEST_W | Per-pin destination |
| cfg_dmode | input | NPINS | Per-pin destination mode, 0 = physical |
| cfg_dlv | input | NPINS*DLV_W | Per-pin delivery mode |
| rew_valid | input | 1 | Pulse: software rewrote a routing entry |
| rew_pin | input | PIN_W | Index of the rewritten entry |
| eoi_valid | input | 1 | Pulse: end-of-interrupt |
| eoi_vec | input | VEC_W | Vector of the end-of-interrupt |
| remote_irr | output | NPINS | Remote-IRR bits for the routing table |
| msg_valid | output | 1 | Delivery message valid |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_vec | output | VEC_W | Message vector |
| msg_dest | output | DEST_W | Message destination |
| msg_dmode | output | 1 | Message destination mode |
| msg_dlv | output | DLV_W | Message delivery mode |
| msg_trig | output | 1 | Message trigger kind |
| msg_assert | output | 1 | Message asserted flag |
| msg_shorthand | output | SHORT_W | Message destination shorthand |

## Verification
The bench goes after the interlock corners:
- an EOI with a foreign vector, which a design that ignores the vector compare would wrongly accept;
- a level pin that drops before its EOI, which a design that forgets to clear pending would deliver a second time;
- a rewrite of a pending level entry, which a design lacking the rewrite path would leave stuck with remote IRR set.

It also raises an edge while the pin is masked; a design that latches that edge would deliver it on unmask. It checks the pin-0 override against an ordinary pin, which catches an override applied to the wrong pin. Three pins are raised together under back-pressure, which exposes a wrong priority order or a message that changes while stalled.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  parameter int VEC_W   = 8;
  parameter int DEST_W  = 8;
  parameter int DLV_W   = 3;
  parameter int SHORT_W = 2;

  typedef struct packed {
    logic [VEC_W-1:0]  vec;
    logic [DEST_W-1:0] dest;
    logic              dmode;
    logic [DLV_W-1:0]  dlv;
    logic              trig;
  } route_t;
endpackage

// File: rtl/irq_pin_track.sv
module irq_pin_track
  import irq_arb_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS-1:0]       pin_lvl,
  input  logic [NPINS-1:0]       cfg_mask,
  input  logic [NPINS-1:0]       cfg_pol,
  input  logic [NPINS-1:0]       cfg_trig,
  input  logic [NPINS*VEC_W-1:0] cfg_vec,
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vec,
  input  logic                   rew_valid,
  input  logic [PIN_W-1:0]       rew_pin,
  input  logic [NPINS-1:0]       grant,
  output logic [NPINS-1:0]       req,
  output logic [NPINS-1:0]       rirr
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic eff, rise, eoi_hit, rew_hit, set_r, clr_r;
    logic pend_q, pend_d, flag_q, flag_d, rirr_q, rirr_d, rirr_en;

    // next-state logic
    always_comb begin
      eff     = pin_lvl[i] ^ cfg_pol[i];
      rise    = eff & ~pend_q;
      eoi_hit = eoi_valid & cfg_trig[i] & (cfg_vec[i*VEC_W +: VEC_W] == eoi_vec);
      rew_hit = rew_valid & (rew_pin == PIN_W'(i));
      set_r   = grant[i] & cfg_trig[i];
      clr_r   = eoi_hit | rew_hit;
      rirr_en = set_r | clr_r;
      rirr_d  = set_r;
      pend_d  = eff;
      flag_d  = ~cfg_trig[i] & ~cfg_mask[i] & (rise | (flag_q & ~grant[i]));
      req[i]  = ~cfg_mask[i] & (cfg_trig[i] ? (pend_q & ~rirr_q) : flag_q);
      rirr[i] = rirr_q;
    end

    // registers
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        flag_q <= 1'b0;
        rirr_q <= 1'b0;
      end else begin
        pend_q <= pend_d;
        flag_q <= flag_d;
        if (rirr_en) rirr_q <= rirr_d;
      end
    end

    // R5: a level grant locks the pin
    a_r5_rirr_set: assert property (@(posedge clk) disable iff (!rst_n)
      set_r |=> rirr_q);
    // R6 / R9: a matching EOI or rewrite unlocks it unless regranted
    a_r6_eoi_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_r && !set_r) |=> !rirr_q);
    // R3: an edge pin never requests twice for one rise
    a_r3_edge_once: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[i] && !cfg_trig[i] && !rise) |=> !flag_q);
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NPINS = 24,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic [NPINS-1:0] req,
  input  logic             take,
  output logic             any,
  output logic [PIN_W-1:0] idx,
  output logic [NPINS-1:0] grant
);
  localparam logic [NPINS-1:0] ONE = NPINS'(1);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = PIN_W'(i);
      end
    end
    grant = (take && any) ? (ONE << idx) : '0;
  end
endmodule

// File: rtl/irq_msg_slot.sv
module irq_msg_slot
  import irq_arb_pkg::*;
#(
  parameter int NPINS = 24,
  parameter logic [DEST_W-1:0] BOOT_DEST = '0,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any,
  input  logic [PIN_W-1:0] pin_in,
  input  route_t           route_in,
  input  logic             msg_ready,
  output logic             free,
  output logic             msg_valid,
  output route_t           msg
);
  logic       valid_q, valid_d, load;
  logic [PIN_W-1:0] pin_q;
  route_t     msg_q, msg_d;

  always_comb begin
    free    = ~valid_q | msg_ready;
    load    = free & any;
    valid_d = free ? any : valid_q;
    msg_d   = route_in;
    if (pin_in == '0) begin
      msg_d.dmode = 1'b0;
      msg_d.dest  = BOOT_DEST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pin_q   <= '0;
      msg_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (load) begin
        pin_q <= pin_in;
        msg_q <= msg_d;
      end
    end
  end

  assign msg_valid = valid_q;
  assign msg       = msg_q;

  // R12: a stalled message stays put
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !msg_ready) |=> (valid_q && $stable(msg_q)));
  // R10: pin 0 always goes physical to the boot destination
  a_r10_boot: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && pin_q == '0) |-> (!msg_q.dmode && msg_q.dest == BOOT_DEST));
endmodule

// File: rtl/irq_pin_arbiter.sv
module irq_pin_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NPINS = 24,
  parameter logic [DEST_W-1:0] BOOT_DEST = '0,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPINS-1:0]        pin_lvl,
  input  logic [NPINS-1:0]        cfg_mask,
  input  logic [NPINS-1:0]        cfg_pol,
  input  logic [NPINS-1:0]        cfg_trig,
  input  logic [NPINS*VEC_W-1:0]  cfg_vec,
  input  logic [NPINS*DEST_W-1:0] cfg_dest,
  input  logic [NPINS-1:0]        cfg_dmode,
  input  logic [NPINS*DLV_W-1:0]  cfg_dlv,
  input  logic                    rew_valid,
  input  logic [PIN_W-1:0]        rew_pin,
  input  logic                    eoi_valid,
  input  logic [VEC_W-1:0]        eoi_vec,
  output logic [NPINS-1:0]        remote_irr,
  output logic                    msg_valid,
  input  logic                    msg_ready,
  output logic [VEC_W-1:0]        msg_vec,
  output logic [DEST_W-1:0]       msg_dest,
  output logic                    msg_dmode,
  output logic [DLV_W-1:0]        msg_dlv,
  output logic                    msg_trig,
  output logic                    msg_assert,
  output logic [SHORT_W-1:0]      msg_shorthand
);
  logic [NPINS-1:0] req, grant;
  logic             any, free;
  logic [PIN_W-1:0] win_idx;
  route_t           route_arr [NPINS];
  route_t           win_route, msg;

  for (genvar i = 0; i < NPINS; i++) begin : g_route
    assign route_arr[i].vec   = cfg_vec[i*VEC_W +: VEC_W];
    assign route_arr[i].dest  = cfg_dest[i*DEST_W +: DEST_W];
    assign route_arr[i].dmode = cfg_dmode[i];
    assign route_arr[i].dlv   = cfg_dlv[i*DLV_W +: DLV_W];
    assign route_arr[i].trig  = cfg_trig[i];
  end

  assign win_route = route_arr[win_idx];

  irq_pin_track #(.NPINS(NPINS)) u_track (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .cfg_mask(cfg_mask),
    .cfg_pol(cfg_pol), .cfg_trig(cfg_trig), .cfg_vec(cfg_vec),
    .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .rew_valid(rew_valid),
    .rew_pin(rew_pin), .grant(grant), .req(req), .rirr(remote_irr)
  );

  irq_prio_pick #(.NPINS(NPINS)) u_pick (
    .req(req), .take(free), .any(any), .idx(win_idx), .grant(grant)
  );

  irq_msg_slot #(.NPINS(NPINS), .BOOT_DEST(BOOT_DEST)) u_slot (
    .clk(clk), .rst_n(rst_n), .any(any), .pin_in(win_idx),
    .route_in(win_route), .msg_ready(msg_ready), .free(free),
    .msg_valid(msg_valid), .msg(msg)
  );

  assign msg_vec       = msg.vec;
  assign msg_dest      = msg.dest;
  assign msg_dmode     = msg.dmode;
  assign msg_dlv       = msg.dlv;
  assign msg_trig      = msg.trig;
  assign msg_assert    = 1'b1;
  assign msg_shorthand = '0;

  // R8: no grant ever goes to a masked pin
  a_r8_no_masked_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> ((grant & cfg_mask) == '0));
  // R12: at most one pin granted per cycle
  a_r12_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R12: no lower-numbered requester is passed over
  a_r12_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> ((req & (grant - NPINS'(1))) == '0));
  // R5: a level pin with remote IRR set is never granted
  a_r5_no_regrant: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> ((grant & cfg_trig & remote_irr) == '0));
endmodule

// File: tb/sim_irq_pin_arbiter.sv
module sim_irq_pin_arbiter;
  localparam int CLK_P = 10;
  localparam int NP = 24;
  localparam int PW = $clog2(NP);
  localparam logic [7:0] BOOT = 8'h5A;

  logic clk, rst_n;
  logic [NP-1:0] pin_lvl, cfg_mask, cfg_pol, cfg_trig, cfg_dmode;
  logic [NP*8-1:0] cfg_vec, cfg_dest;
  logic [NP*3-1:0] cfg_dlv;
  logic rew_valid, eoi_valid, msg_ready;
  logic [PW-1:0] rew_pin;
  logic [7:0] eoi_vec;
  logic [NP-1:0] remote_irr;
  logic msg_valid, msg_dmode, msg_trig, msg_assert;
  logic [7:0] msg_vec, msg_dest;
  logic [2:0] msg_dlv;
  logic [1:0] msg_shorthand;

  int total = 0, bad = 0;
  int qv[$], qd[$], qm[$], qt[$];

  irq_pin_arbiter #(.NPINS(NP), .BOOT_DEST(BOOT)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .cfg_mask(cfg_mask),
    .cfg_pol(cfg_pol), .cfg_trig(cfg_trig), .cfg_vec(cfg_vec),
    .cfg_dest(cfg_dest), .cfg_dmode(cfg_dmode), .cfg_dlv(cfg_dlv),
    .rew_valid(rew_valid), .rew_pin(rew_pin), .eoi_valid(eoi_valid),
    .eoi_vec(eoi_vec), .remote_irr(remote_irr), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vec(msg_vec), .msg_dest(msg_dest),
    .msg_dmode(msg_dmode), .msg_dlv(msg_dlv), .msg_trig(msg_trig),
    .msg_assert(msg_assert), .msg_shorthand(msg_shorthand)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_pend[NP], m_flag[NP], m_rirr[NP];
  bit m_valid, m_dmode, m_trig;
  int m_vec, m_dest, m_dlv;
  int win;
  bit fr, eff, rise, g, rq;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin
        m_pend[i] = 0; m_flag[i] = 0; m_rirr[i] = 0;
      end
      m_valid = 0; m_vec = 0; m_dest = 0; m_dmode = 0; m_trig = 0; m_dlv = 0;
    end else begin
      if (msg_valid && msg_ready) begin
        qv.push_back(msg_vec); qd.push_back(msg_dest);
        qm.push_back(msg_dmode); qt.push_back(msg_trig);
        chk("R11 asserted flag", msg_assert, 1);
        chk("R11 shorthand", msg_shorthand, 0);
      end
      fr = !m_valid || msg_ready;
      win = -1;
      for (int i = NP - 1; i >= 0; i--) begin
        rq = !cfg_mask[i] && (cfg_trig[i] ? (m_pend[i] && !m_rirr[i]) : m_flag[i]);
        if (rq) win = i;
      end
      if (fr) begin
        if (win >= 0) begin
          m_valid = 1;
          m_vec   = cfg_vec[win*8 +: 8];
          m_dest  = (win == 0) ? BOOT : cfg_dest[win*8 +: 8];
          m_dmode = (win == 0) ? 1'b0 : cfg_dmode[win];
          m_dlv   = cfg_dlv[win*3 +: 3];
          m_trig  = cfg_trig[win];
        end else m_valid = 0;
      end else win = -1;
      for (int i = 0; i < NP; i++) begin
        eff  = pin_lvl[i] ^ cfg_pol[i];
        rise = eff && !m_pend[i];
        g    = (win == i);
        if (g && cfg_trig[i]) m_rirr[i] = 1;
        else if ((eoi_valid && cfg_trig[i] && cfg_vec[i*8 +: 8] == eoi_vec) ||
                 (rew_valid && rew_pin == PW'(i))) m_rirr[i] = 0;
        m_flag[i] = !cfg_trig[i] && !cfg_mask[i] && (rise || (m_flag[i] && !g));
        m_pend[i] = eff;
      end
    end
    #(CLK_P/4);
    if (rst_n) begin
      chk("MODEL msg_valid", msg_valid, m_valid);
      if (m_valid) begin
        chk("MODEL msg_vec", msg_vec, m_vec);
        chk("MODEL msg_dest", msg_dest, m_dest);
        chk("MODEL msg_dmode", msg_dmode, m_dmode);
        chk("MODEL msg_dlv", msg_dlv, m_dlv);
        chk("MODEL msg_trig", msg_trig, m_trig);
      end
      for (int i = 0; i < NP; i++) chk("MODEL remote_irr", remote_irr[i], m_rirr[i]);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_valid = 1; eoi_vec = v; tick(1); eoi_valid = 0;
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    rst_n = 0; pin_lvl = '0; cfg_mask = '1; cfg_pol = '0; cfg_trig = '0;
    cfg_dmode = '1; rew_valid = 0; rew_pin = '0; eoi_valid = 0; eoi_vec = '0;
    msg_ready = 1;
    for (int i = 0; i < NP; i++) begin
      cfg_vec[i*8 +: 8]  = 8'(8'h20 + i);
      cfg_dest[i*8 +: 8] = 8'(8'h40 + i);
      cfg_dlv[i*3 +: 3]  = 3'(i % 8);
    end
    tick(3); rst_n = 1; tick(2);
    chk("R1 msg_valid after reset", msg_valid, 0);
    chk("R1 remote_irr after reset", remote_irr, 0);

    // R3 edge pin 3
    cfg_mask[3] = 0; tick(1); pin_lvl[3] = 1; tick(5);
    chk("R3 one message on rise", qv.size(), 1);
    chk("R3 vector", qv[0], 8'h23);
    chk("R3 trig edge", qt[0], 0);
    tick(5);
    chk("R3 no repeat while high", qv.size(), 1);
    pin_lvl[3] = 0; tick(2); pin_lvl[3] = 1; tick(5);
    chk("R3 second rise", qv.size(), 2);

    // R2 polarity on pin 4
    pin_lvl[4] = 1; cfg_pol[4] = 1; cfg_mask[4] = 0; tick(5);
    chk("R2 inverted high is inactive", qv.size(), 2);
    pin_lvl[4] = 0; tick(5);
    chk("R2 inverted low delivers", qv.size(), 3);
    chk("R2 vector", qv[2], 8'h24);

    // R4 / R5 level pin 5
    cfg_trig[5] = 1; cfg_mask[5] = 0; tick(1); pin_lvl[5] = 1; tick(5);
    chk("R4 level delivers", qv.size(), 4);
    chk("R4 trig level", qt[3], 1);
    chk("R5 remote irr set", remote_irr[5], 1);
    tick(6);
    chk("R5 no repeat", qv.size(), 4);

    // R6 EOI
    eoi(8'h99); tick(3);
    chk("R6 foreign eoi keeps irr", remote_irr[5], 1);
    chk("R6 foreign eoi no message", qv.size(), 4);
    eoi(8'h25); tick(5);
    chk("R6 matching eoi redelivers", qv.size(), 5);
    chk("R6 irr set again", remote_irr[5], 1);

    // R7 drop before EOI
    pin_lvl[5] = 0; tick(2); eoi(8'h25); tick(5);
    chk("R7 no redelivery after drop", qv.size(), 5);
    chk("R7 irr cleared", remote_irr[5], 0);

    // R9 rewrite
    pin_lvl[5] = 1; tick(5);
    chk("R9 setup delivery", qv.size(), 6);
    rew_valid = 1; rew_pin = PW'(5); tick(1); rew_valid = 0; tick(5);
    chk("R9 rewrite reservices", qv.size(), 7);
    chk("R9 irr after reservice", remote_irr[5], 1);

    // R8 mask
    pin_lvl[6] = 1; tick(5);
    chk("R8 masked edge silent", qv.size(), 7);
    cfg_mask[6] = 0; tick(5);
    chk("R8 masked edge discarded", qv.size(), 7);
    cfg_trig[7] = 1; pin_lvl[7] = 1; tick(5);
    chk("R8 masked level silent", qv.size(), 7);
    chk("R8 masked level irr", remote_irr[7], 0);
    cfg_mask[7] = 0; rew_valid = 1; rew_pin = PW'(7); tick(1); rew_valid = 0; tick(5);
    chk("R9 unmask rewrite delivers", qv.size(), 8);
    chk("R9 vector", qv[7], 8'h27);

    // R10 pin 0 override
    cfg_mask[0] = 0; pin_lvl[0] = 1; tick(5);
    chk("R10 pin0 delivered", qv.size(), 9);
    chk("R10 pin0 dest", qd[8], BOOT);
    chk("R10 pin0 physical", qm[8], 0);
    chk("R10 other pin dest", qd[0], 8'h43);
    chk("R10 other pin mode", qm[0], 1);

    // R12 priority and stall
    msg_ready = 0; cfg_mask[12:10] = 3'b000; pin_lvl[12:10] = 3'b111; tick(4);
    chk("R12 valid under stall", msg_valid, 1);
    chk("R12 lowest first", msg_vec, 8'h2A);
    tick(3);
    chk("R12 held while stalled", msg_vec, 8'h2A);
    chk("R12 nothing taken", qv.size(), 9);
    msg_ready = 1; tick(6);
    chk("R12 three taken", qv.size(), 12);
    chk("R12 order 1", qv[9], 8'h2A);
    chk("R12 order 2", qv[10], 8'h2B);
    chk("R12 order 3", qv[11], 8'h2C);
    tick(2);
    finish_run();
  end
endmodule